// File: doc/BRIEF.md
# PHY Liveness Scan Arbiter

This block sits between a management register interface and a management-bus frame engine, which serialises MDIO frames on the wire. While its enable input is high, it polls every PHY address in turn with a background read of one fixed register. It then records, one bit per address, whether the addressed PHY acknowledged. Software-initiated accesses share the same frame engine. The arbiter grants them ahead of the next background poll, so a user access never waits longer than the one poll frame that may already be on the bus.

User requests enter through a valid/ready port. A request is taken in the cycle where valid and ready are both high. Once valid is raised, the requester must hold valid and all request fields steady until that cycle. Ready is high only while no frame is in flight, so back-pressure lasts at most one frame. The result comes back as a one-cycle response pulse with no ready; the requester must be able to take it.

The frame engine sees one `fe_start` pulse per frame, with the frame fields valid in that cycle. It answers with one `fe_done` pulse that carries the acknowledge bit and the read data. The `idle` output reports that the bus is quiet.

Top module: `phy_scan_arbiter`

## Requirements
- R1: After reset the alive bitmap is all zeros, no frame is started while enable is low, and `idle` is high.
- R2: While enabled, background frames are reads (`fe_write` = 0) of register `SCAN_REG` (default 1). They visit addresses 0, 1, … `NUM_PHY`-1 and then wrap to 0.
- R3: When a background frame completes, its `fe_ack` value is written into the alive bit for the polled address and is visible in the next cycle. All other bits keep their value.
- R4: `usr_req_ready` is high only while no frame is in flight. A request is taken when valid and ready are both high, and it is started in that same cycle.
- R5: A user request pending in the same cycle as a possible background poll wins. A request that arrives during a poll frame starts in the cycle right after that frame's `fe_done`.
- R6: After a user frame, background polling continues at the address after the last one polled, with no address skipped or repeated.
- R7: A user frame passes write flag, PHY address, register address and write data to the engine with `fe_start`. `usr_rsp_valid` pulses in the cycle of that frame's `fe_done`, carrying `fe_ack` and `fe_rdata`.
- R8: When enable goes low, a poll frame already in flight completes and is recorded, and no further poll starts. The next enable starts again at address 0.
- R9: `idle` is high exactly when no frame is in flight and none is being started.
- R10: An `fe_done` pulse with no frame in flight is ignored: the alive bitmap is unchanged and no response is produced.
- R11: At most one frame is in flight: `fe_start` is never raised before the previous frame's `fe_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_en | input | 1 | Enables background polling |
| usr_req_valid | input | 1 | User request valid |
| usr_req_ready | output | 1 | User request accepted when high with valid |
| usr_req_write | input | 1 | 1 = write frame, 0 = read frame |
| usr_req_phy | input | 5 | User PHY address |
| usr_req_reg | input | 5 | User register address |
| usr_req_wdata | input | 16 | User write data |
| usr_rsp_valid | output | 1 | One-cycle response pulse for a user frame |
| usr_rsp_ack | output | 1 | Acknowledge of the user frame |
| usr_rsp_rdata | output | 16 | Read data of the user frame |
| fe_start | output | 1 | Frame start pulse to the engine |
| fe_write | output | 1 | Frame direction, valid with fe_start |
| fe_phy | output | 5 | Frame PHY address, valid with fe_start |
| fe_reg | output | 5 | Frame register address, valid with fe_start |
| fe_wdata | output | 16 | Frame write data, valid with fe_start |
| fe_done | input | 1 | Frame completion pulse from the engine |
| fe_ack | input | 1 | Acknowledge result, valid with fe_done |
| fe_rdata | input | 16 | Read data, valid with fe_done |
| alive_map | output | NUM_PHY | One bit per address, set when the last poll was acknowledged |
| idle | output | 1 | No frame in flight or starting |

## Verification
The bench builds the block with `NUM_PHY` = 8 and `SCAN_REG` = 1, against an engine model that answers each frame three cycles after its start. The small address space makes the polling loop wrap every eight frames, so the bench can try all 256 responder patterns. For each pattern it confirms that the alive bitmap matches the pattern exactly. The short frame also lets the bench place user requests, enable drops and stray completions at precise points inside a poll frame.

// File: rtl/mdio_scan_pkg.sv
package mdio_scan_pkg;
  localparam int MDIO_ADDR_W = 5;
  localparam int MDIO_DATA_W = 16;

  typedef enum logic [1:0] {
    ARB_IDLE = 2'd0,
    ARB_SCAN = 2'd1,
    ARB_USER = 2'd2
  } arb_state_e;

  typedef struct packed {
    logic                   wr;
    logic [MDIO_ADDR_W-1:0] phy;
    logic [MDIO_ADDR_W-1:0] regad;
    logic [MDIO_DATA_W-1:0] wdata;
  } frame_req_t;
endpackage

// File: rtl/mdio_scan_ptr.sv
module mdio_scan_ptr #(
  parameter int NUM_PHY = 32,
  localparam int PTR_W = (NUM_PHY > 1) ? $clog2(NUM_PHY) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  output logic [PTR_W-1:0] ptr
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_PHY - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (adv) begin
      ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end else if (clr) begin
      ptr <= '0;
    end
  end
endmodule

// File: rtl/mdio_alive_map.sv
module mdio_alive_map #(
  parameter int NUM_PHY = 32,
  localparam int PTR_W = (NUM_PHY > 1) ? $clog2(NUM_PHY) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [PTR_W-1:0]   wr_idx,
  input  logic               wr_val,
  output logic [NUM_PHY-1:0] map
);
  for (genvar i = 0; i < NUM_PHY; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        map[i] <= 1'b0;
      end else if (wr_en && (wr_idx == PTR_W'(i))) begin
        map[i] <= wr_val;
      end
    end
  end
endmodule

// File: rtl/mdio_arb_fsm.sv
module mdio_arb_fsm
  import mdio_scan_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic scan_en,
  input  logic usr_valid,
  input  logic fe_done,
  output logic idle_st,
  output logic start_user,
  output logic start_scan,
  output logic scan_fin,
  output logic user_fin
);
  arb_state_e state_q, state_d;

  assign idle_st    = (state_q == ARB_IDLE);
  assign start_user = idle_st && usr_valid;
  assign start_scan = idle_st && !usr_valid && scan_en;
  assign scan_fin   = (state_q == ARB_SCAN) && fe_done;
  assign user_fin   = (state_q == ARB_USER) && fe_done;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ARB_IDLE: begin
        if (start_user)      state_d = ARB_USER;
        else if (start_scan) state_d = ARB_SCAN;
      end
      ARB_SCAN: if (fe_done) state_d = ARB_IDLE;
      ARB_USER: if (fe_done) state_d = ARB_IDLE;
      default:               state_d = ARB_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ARB_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/phy_scan_arbiter.sv
module phy_scan_arbiter
  import mdio_scan_pkg::*;
#(
  parameter int NUM_PHY  = 32,
  parameter int SCAN_REG = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scan_en,
  input  logic               usr_req_valid,
  output logic               usr_req_ready,
  input  logic               usr_req_write,
  input  logic [4:0]         usr_req_phy,
  input  logic [4:0]         usr_req_reg,
  input  logic [15:0]        usr_req_wdata,
  output logic               usr_rsp_valid,
  output logic               usr_rsp_ack,
  output logic [15:0]        usr_rsp_rdata,
  output logic               fe_start,
  output logic               fe_write,
  output logic [4:0]         fe_phy,
  output logic [4:0]         fe_reg,
  output logic [15:0]        fe_wdata,
  input  logic               fe_done,
  input  logic               fe_ack,
  input  logic [15:0]        fe_rdata,
  output logic [NUM_PHY-1:0] alive_map,
  output logic               idle
);
  localparam int PTR_W = (NUM_PHY > 1) ? $clog2(NUM_PHY) : 1;

  logic             idle_st, start_user, start_scan, scan_fin, user_fin;
  logic [PTR_W-1:0] ptr;
  frame_req_t       scan_req, user_req, sel_req;

  mdio_arb_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .scan_en    (scan_en),
    .usr_valid  (usr_req_valid),
    .fe_done    (fe_done),
    .idle_st    (idle_st),
    .start_user (start_user),
    .start_scan (start_scan),
    .scan_fin   (scan_fin),
    .user_fin   (user_fin)
  );

  mdio_scan_ptr #(.NUM_PHY(NUM_PHY)) u_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (idle_st && !scan_en),
    .adv   (scan_fin),
    .ptr   (ptr)
  );

  mdio_alive_map #(.NUM_PHY(NUM_PHY)) u_map (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (scan_fin),
    .wr_idx (ptr),
    .wr_val (fe_ack),
    .map    (alive_map)
  );

  always_comb begin
    scan_req.wr    = 1'b0;
    scan_req.phy   = MDIO_ADDR_W'(ptr);
    scan_req.regad = MDIO_ADDR_W'(SCAN_REG);
    scan_req.wdata = '0;
    user_req.wr    = usr_req_write;
    user_req.phy   = usr_req_phy;
    user_req.regad = usr_req_reg;
    user_req.wdata = usr_req_wdata;
    sel_req        = start_user ? user_req : scan_req;
  end

  assign fe_start      = start_user | start_scan;
  assign fe_write      = sel_req.wr;
  assign fe_phy        = sel_req.phy;
  assign fe_reg        = sel_req.regad;
  assign fe_wdata      = sel_req.wdata;

  assign usr_req_ready = idle_st;
  assign usr_rsp_valid = user_fin;
  assign usr_rsp_ack   = fe_ack;
  assign usr_rsp_rdata = fe_rdata;

  assign idle          = idle_st && !fe_start;
endmodule

// File: rtl/phy_scan_arbiter_chk.sv
module phy_scan_arbiter_chk #(
  parameter int NUM_PHY = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               scan_en,
  input logic               usr_req_valid,
  input logic               usr_req_ready,
  input logic               usr_req_write,
  input logic [4:0]         usr_req_phy,
  input logic               usr_rsp_valid,
  input logic               fe_start,
  input logic               fe_write,
  input logic [4:0]         fe_phy,
  input logic               fe_done,
  input logic [NUM_PHY-1:0] alive_map,
  input logic               idle
);
  logic inflight;

  always_ff @(posedge clk) begin
    if (!rst_n)        inflight <= 1'b0;
    else if (fe_start) inflight <= 1'b1;
    else if (fe_done)  inflight <= 1'b0;
  end

  // R11
  single_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fe_start |-> !inflight);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> (!inflight && !fe_start));

  // R9
  quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!inflight && !fe_start) |-> idle);

  // R4
  ready_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    usr_req_ready |-> !inflight);

  // R5
  user_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fe_start && usr_req_valid) |->
      (usr_req_ready && fe_phy == usr_req_phy && fe_write == usr_req_write));

  // R7
  rsp_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    usr_rsp_valid |-> (fe_done && inflight));

  // R8
  stop_scan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_en && !usr_req_valid) |-> !fe_start);

  // R10
  alive_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fe_done && inflight) |=> $stable(alive_map));
endmodule

bind phy_scan_arbiter phy_scan_arbiter_chk #(.NUM_PHY(NUM_PHY)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .scan_en       (scan_en),
  .usr_req_valid (usr_req_valid),
  .usr_req_ready (usr_req_ready),
  .usr_req_write (usr_req_write),
  .usr_req_phy   (usr_req_phy),
  .usr_rsp_valid (usr_rsp_valid),
  .fe_start      (fe_start),
  .fe_write      (fe_write),
  .fe_phy        (fe_phy),
  .fe_done       (fe_done),
  .alive_map     (alive_map),
  .idle          (idle)
);

// File: tb/phy_scan_arbiter_tb_top.sv
module phy_scan_arbiter_tb_top;
  localparam int NPHY = 8;
  localparam int LAT  = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scan_en = 1'b0;
  logic        usr_req_valid = 1'b0;
  logic        usr_req_ready;
  logic        usr_req_write = 1'b0;
  logic [4:0]  usr_req_phy = '0;
  logic [4:0]  usr_req_reg = '0;
  logic [15:0] usr_req_wdata = '0;
  logic        usr_rsp_valid, usr_rsp_ack;
  logic [15:0] usr_rsp_rdata;
  logic        fe_start, fe_write;
  logic [4:0]  fe_phy, fe_reg;
  logic [15:0] fe_wdata;
  logic        fe_done = 1'b0;
  logic        fe_ack = 1'b0;
  logic [15:0] fe_rdata = '0;
  logic [NPHY-1:0] alive_map;
  logic        idle;

  int n_chk = 0;
  int n_err = 0;
  logic [NPHY-1:0] resp_mask = '0;
  logic        eng_busy = 1'b0;
  logic        cap_user = 1'b0;
  logic        after_user = 1'b0;
  logic [4:0]  cap_phy = '0;
  logic [4:0]  cap_reg = '0;
  int          exp_ptr = 0;
  int          scan_cnt = 0;

  always #4 clk = ~clk;

  phy_scan_arbiter #(.NUM_PHY(NPHY), .SCAN_REG(1)) dut_i (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en),
    .usr_req_valid(usr_req_valid), .usr_req_ready(usr_req_ready),
    .usr_req_write(usr_req_write), .usr_req_phy(usr_req_phy),
    .usr_req_reg(usr_req_reg), .usr_req_wdata(usr_req_wdata),
    .usr_rsp_valid(usr_rsp_valid), .usr_rsp_ack(usr_rsp_ack),
    .usr_rsp_rdata(usr_rsp_rdata),
    .fe_start(fe_start), .fe_write(fe_write), .fe_phy(fe_phy),
    .fe_reg(fe_reg), .fe_wdata(fe_wdata),
    .fe_done(fe_done), .fe_ack(fe_ack), .fe_rdata(fe_rdata),
    .alive_map(alive_map), .idle(idle)
  );

  function automatic logic [15:0] model_rdata(input logic [4:0] p, input logic [4:0] r);
    return {6'h2D, p, r};
  endfunction

  function automatic logic model_ack(input logic [4:0] p);
    return (p < NPHY) ? resp_mask[p[2:0]] : 1'b0;
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  // Frame engine model: samples starts at the falling edge, answers LAT cycles later
  initial begin
    forever begin
      @(negedge clk);
      if (fe_done) begin
        fe_done  = 1'b0;
        eng_busy = 1'b0;
      end
      if (fe_start) begin
        eng_busy = 1'b1;
        cap_phy  = fe_phy;
        cap_reg  = fe_reg;
        cap_user = usr_req_valid && usr_req_ready;
        if (!cap_user) begin
          check(fe_phy == 5'(exp_ptr), after_user ? "R6 resume address" : "R2 scan address",
                32'(fe_phy), 32'(exp_ptr));
          check(!fe_write && fe_reg == 5'd1, "R2 scan frame kind",
                {26'd0, fe_write, fe_reg}, 32'd1);
          exp_ptr    = (exp_ptr + 1) % NPHY;
          after_user = 1'b0;
        end else begin
          after_user = 1'b1;
        end
        for (int k = 0; k < LAT; k++) begin
          @(negedge clk);
          check(!fe_start, "R11 start while busy", 32'(fe_start), 32'd0);
        end
        fe_ack   = model_ack(cap_phy);
        fe_rdata = model_rdata(cap_phy, cap_reg);
        fe_done  = 1'b1;
        if (!cap_user) scan_cnt++;
      end
    end
  end

  // Idle monitor
  initial begin
    @(posedge rst_n);
    forever begin
      @(negedge clk); #1;
      check(idle == (!eng_busy && !fe_start), "R9 idle",
            32'(idle), 32'(!eng_busy && !fe_start));
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  task automatic wait_rsp(input string tag, input logic a, input logic [15:0] d);
    do begin @(negedge clk); #1; end while (!usr_rsp_valid);
    check(usr_rsp_ack == a, tag, 32'(usr_rsp_ack), 32'(a));
    check(usr_rsp_rdata == d, tag, 32'(usr_rsp_rdata), 32'(d));
  endtask

  task automatic wait_scan_busy();
    do begin @(negedge clk); #1; end while (!(eng_busy && !fe_done && !cap_user));
  endtask

  initial begin
    logic [4:0] k_phy;
    logic [NPHY-1:0] snap;
    int target;
    int starts;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #1;
    check(alive_map == '0, "R1 alive reset", 32'(alive_map), 32'd0);
    check(idle == 1'b1, "R1 idle reset", 32'(idle), 32'd1);
    check(fe_start == 1'b0, "R1 no start", 32'(fe_start), 32'd0);

    // User read with polling off
    resp_mask = 8'h08;
    @(posedge clk); #1;
    usr_req_valid = 1'b1; usr_req_write = 1'b0; usr_req_phy = 5'd3; usr_req_reg = 5'd2;
    @(negedge clk); #1;
    check(usr_req_ready && fe_start, "R4 immediate accept", {30'd0, usr_req_ready, fe_start}, 32'd3);
    check(fe_phy == 5'd3 && fe_reg == 5'd2 && !fe_write, "R7 read fields",
          {21'd0, fe_write, fe_phy, fe_reg}, {21'd0, 1'b0, 5'd3, 5'd2});
    @(posedge clk); #1 usr_req_valid = 1'b0;
    wait_rsp("R7 read response", 1'b1, model_rdata(5'd3, 5'd2));

    // User write to a silent address
    @(posedge clk); #1;
    usr_req_valid = 1'b1; usr_req_write = 1'b1; usr_req_phy = 5'd6;
    usr_req_reg = 5'd17; usr_req_wdata = 16'h1234;
    @(negedge clk); #1;
    check(fe_start && fe_write && fe_wdata == 16'h1234, "R7 write fields",
          {15'd0, fe_start, fe_wdata}, {15'd0, 1'b1, 16'h1234});
    @(posedge clk); #1 usr_req_valid = 1'b0; usr_req_write = 1'b0;
    wait_rsp("R7 write response", 1'b0, model_rdata(5'd6, 5'd17));

    // Exhaustive responder patterns
    exp_ptr = 0;
    @(posedge clk); #1 scan_en = 1'b1;
    for (int m = 0; m < 256; m++) begin
      @(posedge clk); #1 resp_mask = m[NPHY-1:0];
      target = scan_cnt + NPHY + 1;
      while (scan_cnt < target) @(negedge clk);
      @(posedge clk); @(negedge clk); #1;
      check(alive_map == m[NPHY-1:0], "R3 alive pattern", 32'(alive_map), 32'(m));
    end

    // User request arriving during a poll frame
    resp_mask = 8'hFF;
    wait_scan_busy();
    @(posedge clk); #1;
    usr_req_valid = 1'b1; usr_req_phy = 5'd5; usr_req_reg = 5'd9;
    do begin
      @(negedge clk); #1;
      check(!usr_req_ready, "R5 held off during poll", 32'(usr_req_ready), 32'd0);
    end while (!fe_done);
    @(negedge clk); #1;
    check(usr_req_ready && fe_start && fe_phy == 5'd5, "R5 user next",
          {25'd0, usr_req_ready, fe_start, fe_phy}, {25'd0, 1'b1, 1'b1, 5'd5});
    @(posedge clk); #1 usr_req_valid = 1'b0;
    wait_rsp("R7 deferred response", 1'b1, model_rdata(5'd5, 5'd9));
    repeat (3 * (LAT + 2)) @(negedge clk);

    // Disable during a poll frame
    resp_mask = '0;
    wait_scan_busy();
    k_phy = cap_phy;
    @(posedge clk); #1 scan_en = 1'b0;
    do begin @(negedge clk); #1; end while (eng_busy);
    @(posedge clk); @(negedge clk); #1;
    check(alive_map[k_phy[2:0]] == 1'b0, "R8 in-flight recorded",
          32'(alive_map[k_phy[2:0]]), 32'd0);
    starts = 0;
    for (int c = 0; c < 30; c++) begin
      @(negedge clk); #1;
      if (fe_start) starts++;
    end
    check(starts == 0, "R8 no poll while disabled", 32'(starts), 32'd0);
    check(idle == 1'b1, "R8 idle while disabled", 32'(idle), 32'd1);
    exp_ptr = 0;
    @(posedge clk); #1 scan_en = 1'b1;
    do begin @(negedge clk); #1; end while (!fe_start);
    check(fe_phy == 5'd0, "R8 restart at zero", 32'(fe_phy), 32'd0);

    // Stray completion while nothing is in flight
    @(posedge clk); #1 scan_en = 1'b0;
    do begin @(negedge clk); #1; end while (eng_busy || !idle);
    repeat (2) @(negedge clk);
    #1 snap = alive_map;
    fe_ack = 1'b1; fe_done = 1'b1;
    @(posedge clk); #1;
    check(!usr_rsp_valid, "R10 no response", 32'(usr_rsp_valid), 32'd0);
    @(negedge clk); @(negedge clk); #1;
    check(alive_map == snap, "R10 alive unchanged", 32'(alive_map), 32'(snap));

    summary();
    $finish;
  end
endmodule